// File: doc/BRIEF.md
# Sub-Page Write-Permission Table Walker

This block rules on a single guest write to a 4 KB page when write protection at 128-byte granularity is in force. Each request carries the guest physical address, the two attributes of the second-level leaf entry (its writable flag and its sub-page-protect bit), a global enable and a 4 KB-aligned root pointer for a four-level permission table held in memory. When the sub-page check applies, the block walks the table one entry at a time through a 64-bit read port that allows one outstanding read. It then reports one of four outcomes: allow, permission violation, table miss or table misconfiguration.

Each 4 KB page is split into 32 regions of 128 bytes. The three upper table levels hold pointers to the next table. The last level holds 32 write-permission bits interleaved with 32 reserved bits. A reserved bit that is set anywhere is reported as a misconfiguration. This is kept apart from a not-present entry (a miss) and from a clear permission bit (a violation). For a miss or a misconfiguration an exit-qualification word comes back alongside the result.

Top module: `spp_walker`

## Requirements
- R1: When `ctl_enable` or `leaf_spp` is 0, no memory read is made and the result is the plain leaf outcome: allow (code 0) if `leaf_writable` is 1, violation (code 1) if it is 0. `done_valid` rises in the cycle after the request is accepted.
- R2: When `ctl_enable` and `leaf_spp` are both 1 and `leaf_writable` is 1, the sub-page check is skipped. No memory read is made and the result is allow (code 0) in the cycle after acceptance.
- R3: Otherwise the block makes up to four reads, ordered top level first. The first read goes to the root with its low 12 bits dropped, plus 8 times the index. The indices are address bits [47:39], then [38:30], then [29:21], then [20:12].
- R4: The table base for each lower level is taken from bits PA_W-1:12 of the upper-level entry, with the low 12 bits zero.
- R5: An upper-level entry with any of bits 11:1 or 63:PA_W set ends the walk with misconfiguration (code 3) and qualification 0. This holds even if its bit 0 is clear.
- R6: An upper-level entry with bit 0 clear and no reserved bit set ends the walk with miss (code 2) and qualification 0x800 (only bit 11 set).
- R7: A last-level entry with any odd-numbered bit set ends with misconfiguration (code 3) and qualification 0.
- R8: Otherwise the region index i is address bits [11:7]. The result is allow (code 0) if last-level bit 2i is 1 and violation (code 1) if it is 0. The qualification is 0 in both cases.
- R9: At most one read is outstanding. `mem_req_valid` with its address is held steady until `mem_req_ready`, and it drops after a read is accepted until the response has arrived.
- R10: `req_ready` is 1 only while idle. Each request yields exactly one single-cycle `done_valid` pulse, and `done_gpa` carries the request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write check request |
| req_ready | output | 1 | Block idle, request accepted |
| req_gpa | input | 64 | Guest physical address of the write |
| leaf_writable | input | 1 | Leaf entry grants write |
| leaf_spp | input | 1 | Leaf entry asks for sub-page check |
| ctl_enable | input | 1 | Global sub-page protection enable |
| tbl_root | input | 64 | Root table pointer (low 12 bits ignored) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from the table |
| done_valid | output | 1 | One-cycle result pulse |
| done_result | output | 2 | 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| done_gpa | output | 64 | Address of the judged write |
| done_qual | output | 64 | Exit qualification word |

## Verification
The bench targets the order of the two upper-level checks. It feeds an entry that is both not present and carries a reserved bit; a design that tested presence first would report a miss where a misconfiguration is due. It sets the first reserved address bit (bit PA_W) and the top legal address bit (bit PA_W-1) separately; an off-by-one mask would either flag a good pointer or pass a bad one. It places permission patterns at regions 0 and 31 and puts odd-bit poison next to a set permission bit; a wrong region shift or an even/odd swap there turns an allow into a violation or hides a misconfiguration. It also sets the low root bits and stalls `mem_req_ready` at random; a design that kept the root's low bits or moved its address while stalled would read the wrong entries.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int PAGE_SHIFT  = 12;
    localparam int IDX_BITS    = 9;
    localparam int LEVELS      = 4;
    localparam int LVL_W       = $clog2(LEVELS);
    localparam int REGIONS     = 32;
    localparam int REGION_W    = $clog2(REGIONS);
    localparam int REGION_LSB  = 7;
    localparam int ENTRY_SHIFT = 3;
    localparam int QUAL_MISS_BIT = 11;

    typedef enum logic [1:0] {
        RES_ALLOW  = 2'd0,
        RES_VIOL   = 2'd1,
        RES_MISS   = 2'd2,
        RES_MISCFG = 2'd3
    } spp_result_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic        present;
        logic        rsvd_err;
        logic [63:0] next_base;
    } dir_info_t;

    typedef struct packed {
        logic rsvd_err;
        logic perm;
    } leaf_info_t;

    // Table index of the given level (0 = last level, 3 = root level)
    function automatic logic [IDX_BITS-1:0] level_index(input logic [63:0] gpa,
                                                       input logic [LVL_W-1:0] lvl);
        return gpa[PAGE_SHIFT + IDX_BITS * int'(lvl) +: IDX_BITS];
    endfunction

    function automatic logic [63:0] entry_addr(input logic [63:0] base,
                                               input logic [IDX_BITS-1:0] idx);
        return base | {{(64 - IDX_BITS - ENTRY_SHIFT){1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
    endfunction

    function automatic logic [63:0] qual_for(input spp_result_e res);
        logic [63:0] q;
        q = '0;
        if (res == RES_MISS) q[QUAL_MISS_BIT] = 1'b1;
        return q;
    endfunction

    function automatic logic [63:0] base_mask(input int pa_w);
        return ((64'd1 << pa_w) - 64'd1) & ~((64'd1 << PAGE_SHIFT) - 64'd1);
    endfunction

endpackage

// File: rtl/spp_gate.sv
module spp_gate
    import spp_pkg::*;
(
    input  logic        enable,
    input  logic        spp,
    input  logic        writable,
    output logic        walk_needed,
    output spp_result_e bypass_result
);

    always_comb begin
        walk_needed   = enable && spp && !writable;
        bypass_result = writable ? RES_ALLOW : RES_VIOL;
    end

endmodule

// File: rtl/spp_dir_decode.sv
module spp_dir_decode
    import spp_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [63:0] entry,
    output dir_info_t   info
);

    localparam logic [63:0] ADDR_MASK = base_mask(PA_W);
    localparam logic [63:0] RSVD_MASK = ~(ADDR_MASK | 64'd1);

    always_comb begin
        info.present   = entry[0];
        info.rsvd_err  = |(entry & RSVD_MASK);
        info.next_base = entry & ADDR_MASK;
    end

endmodule

// File: rtl/spp_leaf_decode.sv
module spp_leaf_decode
    import spp_pkg::*;
(
    input  logic [63:0]         entry,
    input  logic [REGION_W-1:0] region,
    output leaf_info_t          info
);

    logic [REGIONS-1:0] perm_bits;
    logic [REGIONS-1:0] odd_bits;

    for (genvar g = 0; g < REGIONS; g++) begin : g_split
        assign perm_bits[g] = entry[2*g];
        assign odd_bits[g]  = entry[2*g + 1];
    end

    always_comb begin
        info.rsvd_err = |odd_bits;
        info.perm     = perm_bits[region];
    end

endmodule

// File: rtl/spp_walker.sv
module spp_walker
    import spp_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_gpa,
    input  logic        leaf_writable,
    input  logic        leaf_spp,
    input  logic        ctl_enable,
    input  logic [63:0] tbl_root,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        done_valid,
    output logic [1:0]  done_result,
    output logic [63:0] done_gpa,
    output logic [63:0] done_qual
);

    localparam logic [63:0] ADDR_MASK = base_mask(PA_W);

    walk_state_e      state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [63:0]      base_q;
    logic [63:0]      gpa_q;

    logic        walk_needed;
    spp_result_e bypass_result;
    dir_info_t   dir_info;
    leaf_info_t  leaf_info;

    logic        fin_valid;
    spp_result_e fin_result;

    spp_gate u_gate (
        .enable        (ctl_enable),
        .spp           (leaf_spp),
        .writable      (leaf_writable),
        .walk_needed   (walk_needed),
        .bypass_result (bypass_result)
    );

    spp_dir_decode #(.PA_W(PA_W)) u_dir (
        .entry (mem_rsp_data),
        .info  (dir_info)
    );

    spp_leaf_decode u_leaf (
        .entry  (mem_rsp_data),
        .region (gpa_q[REGION_LSB +: REGION_W]),
        .info   (leaf_info)
    );

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = entry_addr(base_q, level_index(gpa_q, lvl_q));

    // Outcome of the entry arriving this cycle
    always_comb begin
        fin_valid  = 1'b0;
        fin_result = RES_ALLOW;
        if (state_q == ST_WAIT && mem_rsp_valid) begin
            if (lvl_q != '0) begin
                if (dir_info.rsvd_err) begin
                    fin_valid  = 1'b1;
                    fin_result = RES_MISCFG;
                end else if (!dir_info.present) begin
                    fin_valid  = 1'b1;
                    fin_result = RES_MISS;
                end
            end else begin
                fin_valid  = 1'b1;
                if (leaf_info.rsvd_err)  fin_result = RES_MISCFG;
                else if (leaf_info.perm) fin_result = RES_ALLOW;
                else                     fin_result = RES_VIOL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lvl_q       <= '0;
            base_q      <= '0;
            gpa_q       <= '0;
            done_valid  <= 1'b0;
            done_result <= RES_ALLOW;
            done_gpa    <= '0;
            done_qual   <= '0;
        end else begin
            done_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        gpa_q <= req_gpa;
                        if (walk_needed) begin
                            state_q <= ST_ISSUE;
                            lvl_q   <= LVL_W'(LEVELS - 1);
                            base_q  <= tbl_root & ADDR_MASK;
                        end else begin
                            done_valid  <= 1'b1;
                            done_result <= bypass_result;
                            done_gpa    <= req_gpa;
                            done_qual   <= qual_for(bypass_result);
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (fin_valid) begin
                            state_q     <= ST_IDLE;
                            done_valid  <= 1'b1;
                            done_result <= fin_result;
                            done_gpa    <= gpa_q;
                            done_qual   <= qual_for(fin_result);
                        end else begin
                            state_q <= ST_ISSUE;
                            lvl_q   <= lvl_q - 1'b1;
                            base_q  <= dir_info.next_base;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

module spp_walker_checker #(
    parameter int PA_W = 46
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        leaf_writable,
    input logic        leaf_spp,
    input logic        ctl_enable,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        done_valid,
    input logic [1:0]  done_result,
    input logic [63:0] done_qual
);

    assert_bypass_done_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(ctl_enable && leaf_spp)) |=> done_valid);

    assert_writable_done_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ctl_enable && leaf_spp && leaf_writable)
            |=> (done_valid && done_result == 2'd0));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'd0 && (mem_req_addr >> PA_W) == 64'd0));

    assert_qual_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_result != 2'd2) |-> (done_qual == 64'd0));

    assert_qual_miss_R6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_result == 2'd2) |-> (done_qual == 64'h800));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

endmodule

bind spp_walker spp_walker_checker #(.PA_W(PA_W)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .leaf_writable (leaf_writable),
    .leaf_spp      (leaf_spp),
    .ctl_enable    (ctl_enable),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_result   (done_result),
    .done_qual     (done_qual)
);

// File: tb/spp_walker_test.sv
`timescale 1ns/1ps
module spp_walker_test;

    localparam int PA_W = 46;
    localparam logic [63:0] AMASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;
    localparam logic [63:0] RMASK = ~(AMASK | 64'd1);
    localparam logic [63:0] ODD   = 64'hAAAA_AAAA_AAAA_AAAA;
    localparam logic [63:0] EVEN  = 64'h5555_5555_5555_5555;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_gpa = '0;
    logic        leaf_writable = 1'b0;
    logic        leaf_spp = 1'b0;
    logic        ctl_enable = 1'b0;
    logic [63:0] tbl_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done_valid;
    logic [1:0]  done_result;
    logic [63:0] done_gpa;
    logic [63:0] done_qual;

    int tests = 0;
    int fails = 0;
    int cycles_total = 0;

    logic [63:0] ent [4];       // ent[3] = root level ... ent[0] = last level
    logic [63:0] addr_log [4];
    logic [63:0] exp_addr [4];
    int          nreads = 0;
    int          start  = 0;
    logic [1:0]  exp_res;
    int          exp_n;

    always #2 clk = ~clk;

    spp_walker #(.PA_W(PA_W)) uut (.*);

    // Memory model: random ready, one-cycle response
    always @(posedge clk) begin
        if (rst) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_req_ready <= ($urandom % 4) != 0;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (nreads - start < 4) begin
                    addr_log[nreads - start] <= mem_req_addr;
                    mem_rsp_data <= ent[3 - (nreads - start)];
                end else begin
                    mem_rsp_data <= '0;
                end
                mem_rsp_valid <= 1'b1;
                nreads <= nreads + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles_total <= cycles_total + 1;
        if (cycles_total > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected outcome from the requirements
    task automatic model(input logic [63:0] gpa, input logic [63:0] root,
                         input logic en, input logic spp, input logic wr);
        logic [63:0] base;
        logic        stop;
        exp_n = 0;
        stop  = 1'b0;
        if (!(en && spp)) begin
            exp_res = wr ? 2'd0 : 2'd1;          // R1
        end else if (wr) begin
            exp_res = 2'd0;                      // R2
        end else begin
            base = root & AMASK;                 // R3
            for (int l = 3; l >= 1; l--) begin
                if (!stop) begin
                    exp_addr[3 - l] = base | (64'((gpa >> (12 + 9 * l)) & 64'h1FF) << 3);
                    exp_n = exp_n + 1;
                    if ((ent[l] & RMASK) != 0) begin
                        exp_res = 2'd3; stop = 1'b1;  // R5
                    end else if (!ent[l][0]) begin
                        exp_res = 2'd2; stop = 1'b1;  // R6
                    end else begin
                        base = ent[l] & AMASK;        // R4
                    end
                end
            end
            if (!stop) begin
                exp_addr[3] = base | (64'((gpa >> 12) & 64'h1FF) << 3);
                exp_n = 4;
                if ((ent[0] & ODD) != 0) exp_res = 2'd3;                 // R7
                else exp_res = ent[0][2 * int'(gpa[11:7])] ? 2'd0 : 2'd1; // R8
            end
        end
    endtask

    task automatic run_txn(input string tag, input logic [63:0] gpa, input logic [63:0] root,
                           input logic en, input logic spp, input logic wr);
        int cyc;
        model(gpa, root, en, spp, wr);
        @(negedge clk);
        start = nreads;
        check(req_ready == 1'b1, {tag, " R10 ready when idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_gpa = gpa; tbl_root = root;
        ctl_enable = en; leaf_spp = spp; leaf_writable = wr;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done_valid && cyc < 400) begin
            @(negedge clk);
            cyc = cyc + 1;
        end
        check(done_valid == 1'b1, {tag, " R10 done arrives"}, 64'(done_valid), 64'd1);
        check(done_result == exp_res, {tag, " R5 R6 R7 R8 result"}, 64'(done_result), 64'(exp_res));
        check(done_qual == ((exp_res == 2'd2) ? 64'h800 : 64'd0), {tag, " R6 qualification"},
              done_qual, (exp_res == 2'd2) ? 64'h800 : 64'd0);
        check(done_gpa == gpa, {tag, " R10 address"}, done_gpa, gpa);
        check(nreads - start == exp_n, {tag, " R3 read count"}, 64'(nreads - start), 64'(exp_n));
        if (exp_n == 0)
            check(cyc == 1, {tag, " R1 R2 latency"}, 64'(cyc), 64'd1);
        for (int k = 0; k < 4; k++)
            if (k < exp_n && k < nreads - start)
                check(addr_log[k] == exp_addr[k], {tag, " R3 R4 entry address"},
                      addr_log[k], exp_addr[k]);
        @(negedge clk);
        check(done_valid == 1'b0, {tag, " R10 pulse width"}, 64'(done_valid), 64'd0);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic good_tables();
        for (int l = 1; l <= 3; l++) ent[l] = (rnd64() & AMASK) | 64'd1;
        ent[0] = rnd64() & EVEN;
    endtask

    initial begin
        logic [63:0] g;
        int sel, lv, bit_i;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) ent[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0,
              "reset R10 idle outputs", {61'd0, req_ready, mem_req_valid, done_valid}, 64'h4);

        // Directed: bypass paths
        good_tables();
        run_txn("bypass_off_ro R1", rnd64(), rnd64(), 1'b0, 1'b1, 1'b0);
        run_txn("bypass_nospp_rw R1", rnd64(), rnd64(), 1'b1, 1'b0, 1'b1);
        run_txn("spp_writable R2", rnd64(), rnd64(), 1'b1, 1'b1, 1'b1);

        // Directed: region 0 and 31 with root low bits set
        good_tables();
        ent[0] = 64'h1;
        run_txn("region0 allow R8", 64'h0000_1234_5678_9000, 64'hFFF | (rnd64() & AMASK),
                1'b1, 1'b1, 1'b0);
        ent[0] = 64'h1 << 62;
        run_txn("region31 allow R8", 64'h0000_0000_0000_0F80, rnd64(), 1'b1, 1'b1, 1'b0);
        run_txn("region30 viol R8", 64'h0000_0000_0000_0F00, rnd64(), 1'b1, 1'b1, 1'b0);

        // Directed: reserved and presence corner cases
        good_tables();
        ent[3] = 64'h2;
        run_txn("notpresent_rsvd R5", rnd64(), rnd64(), 1'b1, 1'b1, 1'b0);
        good_tables();
        ent[2] = ent[2] | (64'd1 << PA_W);
        run_txn("bitN R5", rnd64(), rnd64(), 1'b1, 1'b1, 1'b0);
        good_tables();
        ent[2] = ent[2] | (64'd1 << (PA_W - 1));
        run_txn("bitNm1 legal R4", rnd64(), rnd64(), 1'b1, 1'b1, 1'b0);
        good_tables();
        ent[1] = ent[1] & ~64'd1;
        run_txn("miss L2 R6", rnd64(), rnd64(), 1'b1, 1'b1, 1'b0);
        good_tables();
        ent[0] = 64'h3;
        run_txn("leaf odd R7", 64'h0, rnd64(), 1'b1, 1'b1, 1'b0);

        // Random mix
        for (int t = 0; t < 150; t++) begin
            good_tables();
            g   = rnd64();
            sel = int'($urandom % 5);
            lv  = int'($urandom % 4);
            if (sel == 1) begin
                if (lv == 0) ent[0] = ent[0] | (64'd1 << (2 * ($urandom % 32) + 1));
                else begin
                    bit_i = ($urandom % 2 == 0) ? int'(1 + $urandom % 11)
                                                : int'(PA_W + $urandom % (64 - PA_W));
                    ent[lv] = ent[lv] | (64'd1 << bit_i);
                end
            end else if (sel == 2) begin
                ent[1 + ($urandom % 3)][0] = 1'b0;
            end
            if (sel == 4)
                run_txn("random bypass R1 R2", g, rnd64(), 1'($urandom), 1'($urandom), 1'($urandom));
            else
                run_txn("random walk R3 R8", g, rnd64(), 1'b1, 1'b1, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule